// File: doc/BRIEF.md
# Formatting buffered UART transmitter

This block takes words of one or more bytes from a producer through a valid/ready handshake, queues them in an internal FIFO, and sends them out one byte at a time as asynchronous serial frames. The bytes of a word leave in either lowest-first or highest-first order.

A formatting stage sits between the FIFO and the serializer. It can pass bytes through unchanged, or it can drop every byte that is not printable text. It can also spell each byte as two uppercase hex digits, with or without a trailing space. A terminator character can optionally follow every word. A second terminator can optionally follow any word that the producer marked as the end of a packet.

Baud timing comes from a fixed whole-number clock divider, and the frame can carry no parity bit, an odd parity bit or an even parity bit. Typical use is a text console or a trace output, where the producer writes raw binary words and the block turns them into readable characters.

Top module: `fmt_uart_tx`

## Requirements
- R1: While reset (active-low `rst_n`, sampled on the rising clock edge) is asserted, and after it is released with nothing written, `txd` stays high and `wr_ready` is high. Reset empties the FIFO, so no frame is sent.
- R2: Each frame has the following bits, in this order:
  - one start bit at 0;
  - eight data bits, least significant bit first;
  - the parity bit, when parity is enabled;
  - one stop bit at 1.
  Every bit lasts `CLK_DIV` clock cycles, and the line idles at 1.
- R3: When `PARITY`=1 (odd), the parity bit makes the count of ones in the data bits plus the parity bit odd. When `PARITY`=2 (even), it makes that count even. When `PARITY`=0, no parity bit is sent.
- R4: A word is accepted on each rising edge where `wr_valid` and `wr_ready` are both high, so back-to-back words go in one per cycle. `wr_ready` drops when the FIFO holds 2^`ASIZE` words. A producer that holds its word until `wr_ready` returns loses nothing, and words leave in the order they were written.
- R5: With `BIG_END`=0, byte 0 (bits 7:0) of a word is sent first. With `BIG_END`=1, the most significant byte is sent first.
- R6: With `MODE`=0, every byte is sent unchanged.
- R7: With `MODE`=1, only bytes in the range 0x20 to 0x7E inclusive are sent. All other bytes are dropped without a trace.
- R8: With `MODE`=2, each byte is sent as two ASCII hex characters, the high nibble first, using '0'-'9' and uppercase 'A'-'F'. `MODE`=3 does the same and then adds a space (0x20) after each byte's two characters.
- R9: When `WTERM_EN`=1, the byte `WTERM_CHR` is sent after every word.
- R10: When `PTERM_EN`=1, the byte `PTERM_CHR` is sent after every word written with `wr_last`=1. If a word-terminator byte is also sent for that word, it comes first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all logic uses its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_data | input | DWIDTH*8 | Word to queue |
| wr_last | input | 1 | Marks the word as the end of a packet |
| wr_valid | input | 1 | Producer offers a word |
| wr_ready | output | 1 | FIFO has room; the word is taken when this and `wr_valid` are high |
| txd | output | 1 | Serial output line, idles high |

## Verification
Four copies of the block, each built with different settings, are driven with short word sequences. Their lines are decoded by bench receivers that sample each bit in the middle of its period and check the start bit, the parity bit and the stop bit.

- The raw copy uses two-byte words. It separates the two byte orders. A burst larger than the FIFO shows that `wr_ready` drops and that the stalled word is still delivered in order.
- The printable copy gets values on both sides of each range limit (0x1F/0x20, 0x7E/0x7F). This exposes an off-by-one in the filter.
- The hex copies use 0xAB, 0x00, 0xFF and 0xE5. These show nibble order, the letter case and digit versus letter selection. Words with and without the last flag separate word-terminator placement from packet-terminator placement.

// File: rtl/fmt_uart_tx.sv
module fmt_uart_tx #(
  parameter int CLK_DIV = 434,
  parameter int PARITY = 0,
  parameter int ASIZE = 10,
  parameter int DWIDTH = 1,
  parameter bit BIG_END = 1'b0,
  parameter int MODE = 0,
  parameter bit WTERM_EN = 1'b0,
  parameter logic [7:0] WTERM_CHR = 8'h0A,
  parameter bit PTERM_EN = 1'b0,
  parameter logic [7:0] PTERM_CHR = 8'h0A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [DWIDTH*8-1:0] wr_data,
  input  logic wr_last,
  input  logic wr_valid,
  output logic wr_ready,
  output logic txd
);
  localparam int DEPTH = 1 << ASIZE;
  localparam int WW = DWIDTH * 8;
  localparam int IW = (DWIDTH > 1) ? $clog2(DWIDTH) : 1;
  localparam int BW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int LAST_PH = (MODE == 3) ? 2 : ((MODE == 2) ? 1 : 0);
  localparam logic [3:0] NBITS = (PARITY != 0) ? 4'd11 : 4'd10;

  // input FIFO
  logic [WW:0] mem [DEPTH];
  logic [ASIZE:0] wp, rp;
  logic full, empty, push, pop;

  assign full = (wp[ASIZE] != rp[ASIZE]) && (wp[ASIZE-1:0] == rp[ASIZE-1:0]);
  assign empty = (wp == rp);
  assign wr_ready = !full;
  assign push = wr_valid && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp[ASIZE-1:0]] <= {wr_last, wr_data};

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ASIZE+1)'(wp - rp) <= (ASIZE+1)'(DEPTH));

  // formatter
  typedef enum logic [1:0] {F_IDLE, F_BYTE, F_WT, F_PT} fst_t;
  fst_t fs;
  logic [WW-1:0] word, wsh;
  logic lastf;
  logic [IW-1:0] bi, sel;
  logic [1:0] ph;
  logic [7:0] cur, hexc, ch;
  logic [3:0] nib;
  logic vld, skip, ser_free, ser_load, adv;
  fst_t after_word;

  assign pop = (fs == F_IDLE) && !empty;
  assign sel = BIG_END ? IW'(DWIDTH - 1) - bi : bi;
  assign wsh = word >> {sel, 3'b000};
  assign cur = wsh[7:0];
  assign nib = (ph == 2'd0) ? cur[7:4] : cur[3:0];
  assign hexc = (nib < 4'd10) ? 8'h30 + {4'h0, nib} : 8'h37 + {4'h0, nib};
  assign after_word = WTERM_EN ? F_WT : ((PTERM_EN && lastf) ? F_PT : F_IDLE);

  always_comb begin
    ch = 8'h00;
    vld = 1'b0;
    case (fs)
      F_BYTE: begin
        if (MODE >= 2) begin
          ch = (ph == 2'd2) ? 8'h20 : hexc;
          vld = 1'b1;
        end else begin
          ch = cur;
          vld = (MODE == 1) ? (cur >= 8'h20 && cur <= 8'h7E) : 1'b1;
        end
      end
      F_WT: begin ch = WTERM_CHR; vld = 1'b1; end
      F_PT: begin ch = PTERM_CHR; vld = 1'b1; end
      default: ;
    endcase
  end

  assign skip = (fs == F_BYTE) && !vld;
  assign ser_load = vld && ser_free;
  assign adv = ser_load || skip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs <= F_IDLE;
      word <= '0;
      lastf <= 1'b0;
      bi <= '0;
      ph <= '0;
    end else if (pop) begin
      word <= mem[rp[ASIZE-1:0]][WW-1:0];
      lastf <= mem[rp[ASIZE-1:0]][WW];
      bi <= '0;
      ph <= '0;
      fs <= F_BYTE;
    end else if (adv) begin
      case (fs)
        F_BYTE:
          if (ph == 2'(LAST_PH)) begin
            ph <= '0;
            if (bi == IW'(DWIDTH - 1)) fs <= after_word;
            else bi <= bi + 1'b1;
          end else ph <= ph + 1'b1;
        F_WT: fs <= (PTERM_EN && lastf) ? F_PT : F_IDLE;
        default: fs <= F_IDLE;
      endcase
    end
  end

  a_r7_printable_only: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 1 && ser_load && fs == F_BYTE) |-> (ch >= 8'h20 && ch <= 8'h7E));
  a_r10_pack_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
    (fs == F_PT) |-> lastf);

  // serializer
  logic busy;
  logic [10:0] sh, frame;
  logic [3:0] left;
  logic [BW-1:0] bc;
  logic pbit, bit_end;

  assign bit_end = (bc == '0);
  assign ser_free = !busy || (bit_end && left == 4'd1);
  assign pbit = (PARITY == 1) ? ~^ch : ^ch;
  assign frame = (PARITY != 0) ? {1'b1, pbit, ch, 1'b0} : {2'b11, ch, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      txd <= 1'b1;
      sh <= '1;
      left <= '0;
      bc <= '0;
    end else if (ser_load) begin
      busy <= 1'b1;
      sh <= frame;
      txd <= 1'b0;
      left <= NBITS;
      bc <= BW'(CLK_DIV - 1);
    end else if (busy) begin
      if (bit_end) begin
        if (left == 4'd1) busy <= 1'b0;
        else begin
          sh <= {1'b1, sh[10:1]};
          txd <= sh[1];
          left <= left - 1'b1;
          bc <= BW'(CLK_DIV - 1);
        end
      end else bc <= bc - 1'b1;
    end
  end

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> txd);
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n) ser_load |=> !txd);
  a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end && !ser_load) |=> $stable(txd));
endmodule

// File: tb/sim_fmt_uart_tx.sv
`timescale 1ns/1ps
module sim_uart_mon #(parameter int DIV = 8, parameter int PAR = 0) (
  input logic clk,
  input logic line
);
  logic [7:0] rxb [64];
  int n = 0;
  int errs = 0;
  initial forever begin
    logic [7:0] b;
    logic p;
    @(negedge line);
    repeat (DIV/2) @(negedge clk);
    if (line !== 1'b0) errs++;
    for (int i = 0; i < 8; i++) begin
      repeat (DIV) @(negedge clk);
      b[i] = line;
    end
    if (PAR != 0) begin
      repeat (DIV) @(negedge clk);
      p = line;
      if (p !== ((PAR == 1) ? ~^b : ^b)) errs++;
    end
    repeat (DIV) @(negedge clk);
    if (line !== 1'b1) errs++;
    rxb[n % 64] = b;
    n++;
  end
endmodule

module sim_fmt_uart_tx;
  localparam int DIV = 8;
  logic clk = 0, rst_n = 0;
  logic [15:0] wd = '0;
  logic wl = 0;
  logic [3:0] wv = '0;
  logic [3:0] rdy;
  logic [3:0] line;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  fmt_uart_tx #(.CLK_DIV(DIV), .PARITY(2), .ASIZE(2), .DWIDTH(2), .BIG_END(1'b0), .MODE(0))
    u0 (.clk(clk), .rst_n(rst_n), .wr_data(wd), .wr_last(wl), .wr_valid(wv[0]), .wr_ready(rdy[0]), .txd(line[0]));
  fmt_uart_tx #(.CLK_DIV(DIV), .PARITY(0), .ASIZE(3), .DWIDTH(1), .MODE(1))
    u1 (.clk(clk), .rst_n(rst_n), .wr_data(wd[7:0]), .wr_last(wl), .wr_valid(wv[1]), .wr_ready(rdy[1]), .txd(line[1]));
  fmt_uart_tx #(.CLK_DIV(DIV), .PARITY(1), .ASIZE(3), .DWIDTH(2), .BIG_END(1'b1), .MODE(3),
                .WTERM_EN(1'b1), .WTERM_CHR(8'h3B), .PTERM_EN(1'b1), .PTERM_CHR(8'h45))
    u2 (.clk(clk), .rst_n(rst_n), .wr_data(wd), .wr_last(wl), .wr_valid(wv[2]), .wr_ready(rdy[2]), .txd(line[2]));
  fmt_uart_tx #(.CLK_DIV(DIV), .PARITY(0), .ASIZE(3), .DWIDTH(1), .MODE(2),
                .PTERM_EN(1'b1), .PTERM_CHR(8'h0A))
    u3 (.clk(clk), .rst_n(rst_n), .wr_data(wd[7:0]), .wr_last(wl), .wr_valid(wv[3]), .wr_ready(rdy[3]), .txd(line[3]));

  sim_uart_mon #(.DIV(DIV), .PAR(2)) m0 (.clk(clk), .line(line[0]));
  sim_uart_mon #(.DIV(DIV), .PAR(0)) m1 (.clk(clk), .line(line[1]));
  sim_uart_mon #(.DIV(DIV), .PAR(1)) m2 (.clk(clk), .line(line[2]));
  sim_uart_mon #(.DIV(DIV), .PAR(0)) m3 (.clk(clk), .line(line[3]));

  function automatic int get_n(int k);
    case (k) 0: return m0.n; 1: return m1.n; 2: return m2.n; default: return m3.n; endcase
  endfunction
  function automatic logic [7:0] get_b(int k, int i);
    case (k) 0: return m0.rxb[i%64]; 1: return m1.rxb[i%64]; 2: return m2.rxb[i%64]; default: return m3.rxb[i%64]; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int k, input logic [15:0] d, input logic last, output bit stalled);
    @(negedge clk);
    wd = d; wl = last; wv[k] = 1'b1;
    stalled = !rdy[k];
    while (!rdy[k]) @(negedge clk);
    @(negedge clk);
    wv[k] = 1'b0;
  endtask

  task automatic wait_bytes(input int k, input int target);
    int t = 0;
    while (get_n(k) < target && t < 20000) begin @(negedge clk); t++; end
    repeat (3 * 11 * DIV) @(negedge clk);
  endtask

  task automatic expect_seq(input int k, input int base, input logic [7:0] e [16], input int ne, input string req);
    wait_bytes(k, base + ne);
    chk(get_n(k) == base + ne, {req, " byte count"}, get_n(k) - base, ne);
    for (int i = 0; i < ne; i++)
      chk(get_b(k, base + i) == e[i], req, get_b(k, base + i), e[i]);
  endtask

  task automatic t_reset;
    chk(line == 4'hF, "R1 txd high in reset", line, 4'hF);
    chk(rdy == 4'hF, "R1 ready in reset", rdy, 4'hF);
    @(negedge clk); rst_n = 1;
    repeat (40) @(negedge clk);
    chk(line == 4'hF, "R1 idle after reset", line, 4'hF);
    chk(m0.n + m1.n + m2.n + m3.n == 0, "R1 no frame after reset", m0.n + m1.n + m2.n + m3.n, 0);
  endtask

  task automatic t_raw_order;
    logic [7:0] e [16];
    bit s;
    int b0 = get_n(0);
    push(0, 16'h4142, 1'b0, s);
    push(0, 16'hC301, 1'b1, s);
    e[0] = 8'h42; e[1] = 8'h41; e[2] = 8'h01; e[3] = 8'hC3;
    expect_seq(0, b0, e, 4, "R5 R6 little-endian raw");
  endtask

  task automatic t_full;
    logic [7:0] e [16];
    bit s;
    int stalls = 0;
    int b0 = get_n(0);
    for (int i = 0; i < 7; i++) begin
      push(0, {8'h20 + 8'(2*i+1), 8'h20 + 8'(2*i)}, 1'b0, s);
      if (s) stalls++;
    end
    chk(stalls > 0, "R4 ready low when full", stalls, 1);
    for (int i = 0; i < 14; i++) e[i] = 8'h20 + 8'(i);
    expect_seq(0, b0, e, 14, "R4 no loss in order");
  endtask

  task automatic t_printable;
    logic [7:0] e [16];
    bit s;
    int b0 = get_n(1);
    push(1, 16'h001F, 1'b0, s);
    push(1, 16'h0020, 1'b0, s);
    push(1, 16'h007E, 1'b0, s);
    push(1, 16'h007F, 1'b0, s);
    push(1, 16'h0041, 1'b1, s);
    push(1, 16'h000A, 1'b0, s);
    e[0] = 8'h20; e[1] = 8'h7E; e[2] = 8'h41;
    expect_seq(1, b0, e, 3, "R7 printable filter");
  endtask

  task automatic t_hexspace;
    logic [7:0] e [16];
    bit s;
    int b0 = get_n(2);
    push(2, 16'hAB01, 1'b0, s);
    push(2, 16'h00FF, 1'b1, s);
    e[0] = "A"; e[1] = "B"; e[2] = " "; e[3] = "0"; e[4] = "1"; e[5] = " "; e[6] = ";";
    e[7] = "0"; e[8] = "0"; e[9] = " "; e[10] = "F"; e[11] = "F"; e[12] = " "; e[13] = ";"; e[14] = "E";
    expect_seq(2, b0, e, 15, "R5 R8 R9 R10 hex-space big-endian");
  endtask

  task automatic t_hex;
    logic [7:0] e [16];
    bit s;
    int b0 = get_n(3);
    push(3, 16'h003C, 1'b0, s);
    push(3, 16'h00E5, 1'b1, s);
    e[0] = "3"; e[1] = "C"; e[2] = "E"; e[3] = "5"; e[4] = 8'h0A;
    expect_seq(3, b0, e, 5, "R8 R10 hex packet terminator");
  endtask

  task automatic t_frames;
    chk(m0.errs == 0, "R2 R3 even parity frames", m0.errs, 0);
    chk(m1.errs == 0, "R2 no-parity frames", m1.errs, 0);
    chk(m2.errs == 0, "R2 R3 odd parity frames", m2.errs, 0);
    chk(m3.errs == 0, "R2 frames", m3.errs, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_raw_order;
    t_full;
    t_printable;
    t_hexspace;
    t_hex;
    t_frames;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R4 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule